// File: doc/BRIEF.md
# Delay-Tap Window Search Engine

This block calibrates the read-capture delay tap of a two-lane memory interface. After a start pulse it tries tap values one at a time. For each trial it loads the same value into both lane tap outputs. It then reads a test region through a request/response read port and compares every returned word against a pattern that it generates itself.

The search first climbs from the starting tap and then falls from the same starting tap. This gives the highest and lowest passing taps. The engine then centres lane 0 on the midpoint of that window and places lane 1 one tap above it.

The memory and the delay lines sit outside the block. The read port returns one word per accepted address, in order. The engine never moves to another tap while reads are still outstanding.

Top module: `tap_cal_engine`

## Requirements
- R1: After reset, `busy`, `cal_done`, `cal_err`, both tap outputs, both limits and `rd_req_valid` are all 0.
- R2: A `start` pulse while idle makes `busy` high in the next cycle and latches `start_tap`. A `start` pulse while `busy` is high has no effect on the search or its results.
- R3: Whenever a read request is presented, `tap_lane0` equals `tap_lane1` and both carry the current trial tap.
- R4: Each trial reads word addresses 0 to WORDS-1 in increasing order, PASSES (2) times. A passing trial issues exactly PASSES*WORDS accepted reads.
- R5: The expected word at address a has group g = a/4 and slot s = a%4. Bits [15:0] are all ones when bit 2s of g is set, and bits [31:16] are all ones when bit 2s+1 of g is set; all other bits are 0. A single mismatching word fails the trial. After a mismatch no further requests are issued, and every outstanding response is taken in before the next tap is applied.
- R6: While climbing, a passing trial at a tap below 32 moves to tap+1. A passing trial at tap 32 or above sets the upper limit to that tap and restarts at the starting tap, now descending.
- R7: While climbing, a failing trial sets the upper limit to tap-1 (0 when the tap is 0) and restarts at the starting tap, now descending.
- R8: While descending, a passing trial moves to tap-1. A pass at tap 0 sets the lower limit to 0 and ends the search. A failing trial sets the lower limit to tap+1 (saturating at 63) and ends the search.
- R9: At the end, `tap_lane0` = floor((upper+lower)/2) and `tap_lane1` = that value plus 1 (saturating at 63). `cal_done` rises, `busy` falls, and all of these hold until the next start.
- R10: `cal_err` is 1 at the end exactly when the lower limit exceeds the upper limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch calibration (pulse) |
| start_tap | input | TAP_W | Tap value the search begins from |
| busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | Calibration finished, results valid |
| cal_err | output | 1 | Lower limit above upper limit |
| lim_upper | output | TAP_W | Highest passing tap found |
| lim_lower | output | TAP_W | Lowest passing tap found |
| tap_lane0 | output | TAP_W | Delay tap for lane 0 |
| tap_lane1 | output | TAP_W | Delay tap for lane 1 |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | log2(WORDS) | Word address of the read |
| rd_rsp_valid | input | 1 | Read data valid (in request order) |
| rd_rsp_data | input | DATA_W | Read data |

## Verification
Two functions can fall in the same cycle. One is the mismatch verdict on the last word of the first pass. The other is the issue of the first request of the second pass, since requests keep flowing while that response is in flight. The bench provokes this by making the modelled memory corrupt word WORDS-1 whenever the tap lies outside its pass window, and by picking a starting tap that is itself outside the window. The result is judged by the trial still being failed, the tap moving only after the drain, and the reported limits, error flag and centred taps matching values worked out from the search rules.

// File: rtl/tapcal_pkg.sv
package tapcal_pkg;

    typedef enum logic [1:0] {
        SRCH_IDLE,
        SRCH_LAUNCH,
        SRCH_WAIT,
        SRCH_CENTER
    } srch_state_t;

    typedef enum logic [1:0] {
        TST_IDLE,
        TST_ISSUE,
        TST_DRAIN,
        TST_REPORT
    } tst_state_t;

endpackage

// File: rtl/tapcal_pattern.sv
module tapcal_pattern #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    localparam int HALF = DATA_W / 2;

    logic [7:0] grp;
    logic [1:0] slot;
    logic       lo_set;
    logic       hi_set;

    always_comb begin
        grp    = 8'(addr >> 2);
        slot   = addr[1:0];
        lo_set = grp[{slot, 1'b0}];
        hi_set = grp[{slot, 1'b1}];
        data   = {{HALF{hi_set}}, {HALF{lo_set}}};
    end
endmodule

// File: rtl/tapcal_mem_tester.sv
module tapcal_mem_tester
    import tapcal_pkg::*;
#(
    parameter int WORDS  = 1024,
    parameter int PASSES = 2,
    parameter int DATA_W = 32,
    localparam int ADDR_W = $clog2(WORDS),
    localparam int TOTAL  = WORDS * PASSES,
    localparam int CNT_W  = $clog2(TOTAL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              trial_done,
    output logic              trial_pass
);
    tst_state_t state_q, state_d;

    logic [CNT_W-1:0]  issue_cnt;
    logic [CNT_W-1:0]  outstanding;
    logic [ADDR_W-1:0] rsp_addr;
    logic [DATA_W-1:0] expected;
    logic              fail_q;
    logic              req_fire;
    logic              last_fire;

    tapcal_pattern #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pattern (
        .addr (rsp_addr),
        .data (expected)
    );

    assign req_fire  = req_valid && req_ready;
    assign last_fire = req_fire && (issue_cnt == CNT_W'(TOTAL - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TST_IDLE:   if (go) state_d = TST_ISSUE;
            TST_ISSUE:  if (fail_q || last_fire) state_d = TST_DRAIN;
            TST_DRAIN:  if (outstanding == '0) state_d = TST_REPORT;
            TST_REPORT: state_d = TST_IDLE;
            default:    state_d = TST_IDLE;
        endcase
    end

    always_comb begin
        req_valid  = (state_q == TST_ISSUE) && !fail_q;
        req_addr   = issue_cnt[ADDR_W-1:0];
        trial_done = (state_q == TST_REPORT);
        trial_pass = !fail_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issue_cnt   <= '0;
            outstanding <= '0;
            rsp_addr    <= '0;
            fail_q      <= 1'b0;
        end else if (state_q == TST_IDLE && go) begin
            issue_cnt   <= '0;
            outstanding <= '0;
            rsp_addr    <= '0;
            fail_q      <= 1'b0;
        end else begin
            if (req_fire) issue_cnt <= issue_cnt + 1'b1;
            outstanding <= outstanding + CNT_W'(req_fire) - CNT_W'(rsp_valid);
            if (rsp_valid) begin
                rsp_addr <= rsp_addr + 1'b1;
                if (rsp_data != expected) fail_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tap_cal_engine.sv
module tap_cal_engine
    import tapcal_pkg::*;
#(
    parameter int TAP_W    = 6,
    parameter int TAP_CEIL = 32,
    parameter int WORDS    = 1024,
    parameter int PASSES   = 2,
    parameter int DATA_W   = 32,
    localparam int ADDR_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TAP_W-1:0]  start_tap,
    output logic              busy,
    output logic              cal_done,
    output logic              cal_err,
    output logic [TAP_W-1:0]  lim_upper,
    output logic [TAP_W-1:0]  lim_lower,
    output logic [TAP_W-1:0]  tap_lane0,
    output logic [TAP_W-1:0]  tap_lane1,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    input  logic              rd_rsp_valid,
    input  logic [DATA_W-1:0] rd_rsp_data
);
    localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};

    srch_state_t state_q, state_d;

    logic [TAP_W-1:0] trial_tap, origin_tap, upper_q, lower_q;
    logic [TAP_W-1:0] lane0_q, lane1_q, mid;
    logic [TAP_W:0]   sum;
    logic             climbing, done_q, err_q;
    logic             trial_go, trial_done, trial_pass, finish_now;

    tapcal_mem_tester #(.WORDS(WORDS), .PASSES(PASSES), .DATA_W(DATA_W)) u_tester (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (trial_go),
        .req_valid  (rd_req_valid),
        .req_ready  (rd_req_ready),
        .req_addr   (rd_req_addr),
        .rsp_valid  (rd_rsp_valid),
        .rsp_data   (rd_rsp_data),
        .trial_done (trial_done),
        .trial_pass (trial_pass)
    );

    assign sum        = {1'b0, upper_q} + {1'b0, lower_q};
    assign mid        = sum[TAP_W:1];
    assign finish_now = !climbing && (!trial_pass || trial_tap == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SRCH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRCH_IDLE:   if (start) state_d = SRCH_LAUNCH;
            SRCH_LAUNCH: state_d = SRCH_WAIT;
            SRCH_WAIT:   if (trial_done) state_d = finish_now ? SRCH_CENTER : SRCH_LAUNCH;
            SRCH_CENTER: state_d = SRCH_IDLE;
            default:     state_d = SRCH_IDLE;
        endcase
    end

    always_comb begin
        busy      = (state_q != SRCH_IDLE);
        trial_go  = (state_q == SRCH_LAUNCH);
        cal_done  = done_q;
        cal_err   = err_q;
        lim_upper = upper_q;
        lim_lower = lower_q;
        tap_lane0 = lane0_q;
        tap_lane1 = lane1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trial_tap  <= '0;
            origin_tap <= '0;
            upper_q    <= '0;
            lower_q    <= '0;
            lane0_q    <= '0;
            lane1_q    <= '0;
            climbing   <= 1'b1;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            unique case (state_q)
                SRCH_IDLE: if (start) begin
                    trial_tap  <= start_tap;
                    origin_tap <= start_tap;
                    upper_q    <= start_tap;
                    lower_q    <= start_tap;
                    climbing   <= 1'b1;
                    done_q     <= 1'b0;
                    err_q      <= 1'b0;
                end
                SRCH_LAUNCH: begin
                    lane0_q <= trial_tap;
                    lane1_q <= trial_tap;
                end
                SRCH_WAIT: if (trial_done) begin
                    if (climbing) begin
                        if (trial_pass && trial_tap < TAP_W'(TAP_CEIL)) begin
                            trial_tap <= trial_tap + 1'b1;
                        end else begin
                            if (trial_pass)            upper_q <= trial_tap;
                            else if (trial_tap == '0)  upper_q <= '0;
                            else                       upper_q <= trial_tap - 1'b1;
                            climbing  <= 1'b0;
                            trial_tap <= origin_tap;
                        end
                    end else if (trial_pass) begin
                        if (trial_tap == '0) lower_q <= '0;
                        else                 trial_tap <= trial_tap - 1'b1;
                    end else begin
                        lower_q <= (trial_tap == TAP_MAX) ? TAP_MAX : trial_tap + 1'b1;
                    end
                end
                SRCH_CENTER: begin
                    lane0_q <= mid;
                    lane1_q <= (mid == TAP_MAX) ? TAP_MAX : mid + 1'b1;
                    err_q   <= (lower_q > upper_q);
                    done_q  <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tap_cal_engine_checker.sv
module tap_cal_engine_checker #(
    parameter int TAP_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             cal_done,
    input logic             cal_err,
    input logic [TAP_W-1:0] lim_upper,
    input logic [TAP_W-1:0] lim_lower,
    input logic [TAP_W-1:0] tap_lane0,
    input logic [TAP_W-1:0] tap_lane1,
    input logic             rd_req_valid,
    input logic             rd_rsp_valid
);
    // R3: both lanes carry one trial value while reads are requested
    a_r3_lanes_match: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> (tap_lane0 == tap_lane1));

    // R2: a start during a run does not end or restart it
    a_r2_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> busy);

    // R5: no read traffic remains once the engine is idle
    a_r5_drained: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_req_valid && !rd_rsp_valid));

    // R9: done and busy are never high together
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |-> !busy);

    // R9: lane 1 ends at most one tap above lane 0
    a_r9_lane_offset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_done) |-> (tap_lane1 >= tap_lane0) && ((tap_lane1 - tap_lane0) <= 1));

    // R10: the error flag matches the reported limits
    a_r10_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |-> (cal_err == (lim_lower > lim_upper)));

    // R9: without an error the centre lies inside the window
    a_r9_centre_inside: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_done && !cal_err) |-> (tap_lane0 >= lim_lower) && (tap_lane0 <= lim_upper));
endmodule

bind tap_cal_engine tap_cal_engine_checker #(.TAP_W(TAP_W)) u_chk (.*);

// File: tb/tap_cal_engine_test.sv
module tap_cal_engine_test;
    localparam int TW = 6;
    localparam int W  = 32;
    localparam int AW = 5;
    localparam int NV = 7;

    // {start, win_lo, win_hi, bad_addr, upper, lower, lane0, lane1, err}
    localparam logic [48:0] VEC [NV] = '{
        {6'd10, 6'd4,  6'd20, 6'd7,  6'd20, 6'd4,  6'd12, 6'd13, 1'b0},
        {6'd31, 6'd0,  6'd63, 6'd31, 6'd32, 6'd0,  6'd16, 6'd17, 1'b0},
        {6'd5,  6'd8,  6'd30, 6'd31, 6'd4,  6'd6,  6'd5,  6'd6,  1'b1},
        {6'd0,  6'd0,  6'd3,  6'd0,  6'd3,  6'd0,  6'd1,  6'd2,  1'b0},
        {6'd0,  6'd1,  6'd9,  6'd12, 6'd0,  6'd1,  6'd0,  6'd1,  1'b1},
        {6'd40, 6'd30, 6'd50, 6'd20, 6'd40, 6'd30, 6'd35, 6'd36, 1'b0},
        {6'd63, 6'd0,  6'd62, 6'd31, 6'd62, 6'd63, 6'd62, 6'd63, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [TW-1:0] start_tap;
    logic          busy, cal_done, cal_err;
    logic [TW-1:0] lim_upper, lim_lower, tap_lane0, tap_lane1;
    logic          rd_req_valid;
    logic          rd_req_ready = 1'b1;
    logic [AW-1:0] rd_req_addr;
    logic          rd_rsp_valid = 1'b0;
    logic [31:0]   rd_rsp_data  = '0;

    int tests_run = 0;
    int tests_failed = 0;
    int win_lo = 0, win_hi = 63, bad_addr = 0;
    int req_count = 0, lane_bad = 0, rdy_cnt = 0;

    always #4 clk = ~clk;

    tap_cal_engine #(.TAP_W(TW), .WORDS(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_tap(start_tap),
        .busy(busy), .cal_done(cal_done), .cal_err(cal_err),
        .lim_upper(lim_upper), .lim_lower(lim_lower),
        .tap_lane0(tap_lane0), .tap_lane1(tap_lane1),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data)
    );

    function automatic logic [31:0] pattern_word(input int a);
        int g;
        int s;
        logic [31:0] w;
        g = a / 4;
        s = a % 4;
        w = '0;
        if (((g >> (2 * s)) & 1) == 1)     w[15:0]  = 16'hFFFF;
        if (((g >> (2 * s + 1)) & 1) == 1) w[31:16] = 16'hFFFF;
        return w;
    endfunction

    // Memory model: one-cycle latency, corrupts one word outside the pass window
    always @(posedge clk) begin
        rdy_cnt      <= rdy_cnt + 1;
        rd_req_ready <= (rdy_cnt % 3) != 1;
        rd_rsp_valid <= rd_req_valid && rd_req_ready;
        if (rd_req_valid && rd_req_ready) begin
            req_count <= req_count + 1;
            if (tap_lane0 != tap_lane1) lane_bad <= lane_bad + 1;
            if ((int'(tap_lane0) < win_lo || int'(tap_lane0) > win_hi) && int'(rd_req_addr) == bad_addr)
                rd_rsp_data <= pattern_word(int'(rd_req_addr)) ^ 32'h1;
            else
                rd_rsp_data <= pattern_word(int'(rd_req_addr));
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        tests_run++;
        if (act != exp) begin
            tests_failed++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    endtask

    task automatic wait_done();
        int cycles = 0;
        while (!cal_done) begin
            @(negedge clk);
            cycles++;
            if (cycles > 40000) begin
                tests_run++;
                tests_failed++;
                $display("FAIL watchdog R9: actual cal_done %0d expected 1", cal_done);
                finish_run();
            end
        end
    endtask

    task automatic launch(input int st);
        @(negedge clk);
        start     = 1'b1;
        start_tap = TW'(st);
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", int'(busy), 1);
    endtask

    initial begin
        rst_n     = 1'b0;
        start     = 1'b0;
        start_tap = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 cal_done", int'(cal_done), 0);
        chk("R1 cal_err", int'(cal_err), 0);
        chk("R1 taps", int'(tap_lane0) + int'(tap_lane1), 0);
        chk("R1 limits", int'(lim_upper) + int'(lim_lower), 0);
        chk("R1 rd_req_valid", int'(rd_req_valid), 0);

        for (int v = 0; v < NV; v++) begin
            win_lo    = int'(VEC[v][42:37]);
            win_hi    = int'(VEC[v][36:31]);
            bad_addr  = int'(VEC[v][30:25]);
            req_count = 0;
            lane_bad  = 0;
            launch(int'(VEC[v][48:43]));
            wait_done();
            chk("R6 R7 upper limit", int'(lim_upper), int'(VEC[v][24:19]));
            chk("R8 lower limit", int'(lim_lower), int'(VEC[v][18:13]));
            chk("R5 R9 lane0 centre", int'(tap_lane0), int'(VEC[v][12:7]));
            chk("R9 lane1 centre", int'(tap_lane1), int'(VEC[v][6:1]));
            chk("R10 error flag", int'(cal_err), int'(VEC[v][0]));
            chk("R9 busy low at end", int'(busy), 0);
            chk("R3 lanes equal on requests", lane_bad, 0);
            // R4: 34 passing trials of 2*W reads each
            if (v == 1) chk("R4 read count", req_count, 34 * 2 * W);
        end

        // R9: results held and no traffic after completion
        repeat (5) @(negedge clk);
        chk("R9 done held", int'(cal_done), 1);
        chk("R9 lane0 held", int'(tap_lane0), 62);
        chk("R5 no requests when idle", int'(rd_req_valid), 0);

        // R2: a start during a run is ignored
        win_lo   = 4;
        win_hi   = 20;
        bad_addr = 7;
        launch(10);
        chk("R2 done cleared by start", int'(cal_done), 0);
        repeat (50) @(negedge clk);
        start     = 1'b1;
        start_tap = 6'd50;
        @(negedge clk);
        start = 1'b0;
        chk("R2 still busy", int'(busy), 1);
        wait_done();
        chk("R2 upper unchanged", int'(lim_upper), 20);
        chk("R2 lower unchanged", int'(lim_lower), 4);
        chk("R2 lane0 unchanged", int'(tap_lane0), 12);

        finish_run();
    end
endmodule